// File: doc/BRIEF.md
# Polyphase Interpolating Complex FIR

This block raises the sample rate of a complex (I/Q) stream by an integer factor L and low-pass filters it in the same pass. It behaves exactly like placing L−1 zeros between consecutive input samples and running an N-tap FIR at the higher rate. It never builds the zero-stuffed stream. Instead, for each output phase p it sums only the taps that meet real samples: h[off + p + k·L] against the k-th newest input. A single multiplier, clocked at the system clock, serves both rails in turn: an I product and then a Q product for every tap.

A 256-word coefficient store can hold several filters side by side. A base offset chooses the active filter, and addresses wrap modulo 256. The last 32 complex inputs are kept in a circular history that clears to zero at reset. The arithmetic is fixed and bit-exact:

- Inputs and coefficients are 1.15.
- Each product is truncated to 2.18.
- The sum is kept in a 4.18 accumulator.
- The result is rounded and saturated to 1.17.

Both stream interfaces use valid/ready. An input is taken in a cycle where `s_valid` and `s_ready` are both high. `s_ready` stays low from that cycle until the L-th output of the sample has been handed off, so the source is stalled while outputs are pending. An output transfers in a cycle where `m_valid` and `m_ready` are both high. While `m_ready` is low, the output word is held unchanged. The configuration pins are plain levels and are captured when a sample is accepted.

Top module: `poly_iq_interp`

## Requirements
- R1: After reset `s_ready` is 1, `m_valid` is 0, and every stored history sample reads as zero.
- R2: An input is accepted on a rising edge with `s_valid` and `s_ready` both high. `s_ready` is 0 from the next cycle until the last output of that sample has transferred, and `m_valid` is never 1 while `s_ready` is 1.
- R3: Every accepted sample yields exactly L outputs, where L = `cfg_l` (legal range 1 to 256). The outputs come in phase order p = 0, 1, …, L−1.
- R4: Output phase p of the newest sample x[0] equals the sum over k ≥ 0 with p + k·L < N of coef[(off + p + k·L) mod 256] · x[k]. Here x[k] is the k-th newest input, N = `cfg_taps` (1 to 256), and ceil(N/L) ≤ 32.
- R5: Each 1.15 × 1.15 product is reduced to 2.18 by dropping its 12 lowest bits (rounding toward minus infinity). Products are summed in a 22-bit two's complement accumulator that wraps, and the accumulator is cleared at the start of every output.
- R6: The 4.18 sum is turned into the 18-bit 1.17 output by adding half an LSB and dropping one bit. A result above 131071 gives 131071, and a result below −131072 gives −131072.
- R7: A product of −1.0 by −1.0 enters the sum as +1.0 (262144 in 2.18), not as a wrapped negative value.
- R8: A coefficient write (`cw_en`, 8-bit `cw_addr`, 16-bit `cw_data`) updates one word. `cfg_off` selects the start of the active filter, and tap addresses wrap from 255 to 0.
- R9: `cfg_l`, `cfg_taps` and `cfg_off` are sampled on the accepting edge. Changing them while outputs are pending has no effect on those outputs.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_i` and `m_q` hold their values on the next cycle.
- R11: A phase p with p ≥ N has no taps, and its output is exactly 0.
- R12: The I and Q rails use the same coefficients and are filtered independently: `s_i` only affects `m_i`, and `s_q` only affects `m_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take an input sample |
| s_i | input | 16 | Input I, 1.15 |
| s_q | input | 16 | Input Q, 1.15 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 8 | Coefficient write address |
| cw_data | input | 16 | Coefficient value, 1.15 |
| cfg_l | input | 9 | Interpolation factor L, 1 to 256 |
| cfg_taps | input | 9 | Filter length N, 1 to 256 |
| cfg_off | input | 8 | Base address of the active filter |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Sink takes the output sample |
| m_i | output | 18 | Output I, 1.17 |
| m_q | output | 18 | Output Q, 1.17 |

## Verification
An impulse on a zeroed history shows each coefficient directly and separates the I and Q rails. Streams of random samples are then run with these settings:

- L = 1 with N = 8.
- L = 4 with N = 16, which divides evenly.
- L = 3 with N = 10, which leaves uneven branch lengths.
- L = 5 with N = 3, where several phases have no taps.
- L = 256 with N = 256, one tap per phase.
- N = 32 with L = 1, which reaches the full history depth.

These streams show whether the branch selection and the sample ages are right. A filter based at 250 checks the address wrap. A full-scale input runs into both saturation limits. A lone −1 × −1 tap tells +1.0 apart from a wrapped value. Small products of ±1 and ±3 LSB separate floor truncation from the final round-half-up. Random back-pressure, and configuration pins that change after every acceptance, check holding and capture.

// File: rtl/piq_pkg.sv
package piq_pkg;

  // Sequencer states of the polyphase engine
  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_PHASE = 3'd1,
    SEQ_MAC_I = 3'd2,
    SEQ_MAC_Q = 3'd3,
    SEQ_OUT   = 3'd4
  } seq_state_t;

  function automatic int unsigned bits_for(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/piq_coef_store.sv
module piq_coef_store #(
  parameter int COEF_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [COEF_W-1:0] rd_data
);

  logic [COEF_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/piq_sample_ring.sv
module piq_sample_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_i,
  input  logic [DATA_W-1:0] push_q,
  input  logic [AW-1:0]     age,
  output logic [DATA_W-1:0] rd_i,
  output logic [DATA_W-1:0] rd_q
);

  logic [AW-1:0]     head;
  logic [AW-1:0]     wr_slot;
  logic [AW-1:0]     rd_slot;
  logic [DATA_W-1:0] cell_i [DEPTH];
  logic [DATA_W-1:0] cell_q [DEPTH];

  assign wr_slot = head + 1'b1;
  assign rd_slot = head - age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    head <= '0;
    else if (push) head <= wr_slot;
  end

  // each cell clears to zero so history before the first sample is silent
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_i[g] <= '0;
        cell_q[g] <= '0;
      end else if (push && (wr_slot == AW'(g))) begin
        cell_i[g] <= push_i;
        cell_q[g] <= push_q;
      end
    end
  end

  assign rd_i = cell_i[rd_slot];
  assign rd_q = cell_q[rd_slot];

endmodule

// File: rtl/piq_mac.sv
module piq_mac #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int IN_FRAC   = 15,
  parameter int PROD_FRAC = 18,
  parameter int ACC_W     = 22,
  parameter int OUT_W     = 18,
  localparam int SHIFT    = 2 * IN_FRAC - PROD_FRAC,
  localparam int FULL_W   = DATA_W + COEF_W,
  localparam int PROD_W   = FULL_W - SHIFT,
  localparam int HEAD_W   = ACC_W - OUT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en_i,
  input  logic              en_q,
  input  logic [DATA_W-1:0] d_i,
  input  logic [DATA_W-1:0] d_q,
  input  logic [COEF_W-1:0] coef,
  output logic [OUT_W-1:0]  y_i,
  output logic [OUT_W-1:0]  y_q
);

  logic signed [DATA_W-1:0] opnd;
  logic signed [FULL_W-1:0] full;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x;
  logic signed [ACC_W-1:0]  acc [2];
  logic        [1:0]        rail_en;

  // one multiplier, shared between rails in alternate cycles
  assign opnd   = en_q ? $signed(d_q) : $signed(d_i);
  assign full   = opnd * $signed(coef);
  assign prod   = PROD_W'(full >>> SHIFT);
  assign prod_x = ACC_W'(prod);
  assign rail_en = {en_q, en_i};

  for (genvar r = 0; r < 2; r++) begin : g_rail
    logic signed [ACC_W-1:0] rnd;
    logic [OUT_W-1:0]        yo;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc[r] <= '0;
      else if (clr)        acc[r] <= '0;
      else if (rail_en[r]) acc[r] <= acc[r] + prod_x;
    end

    // round half up while dropping one fraction bit: floor(a/2) + a[0]
    assign rnd = {acc[r][ACC_W-1], acc[r][ACC_W-1:1]} + ACC_W'(acc[r][0]);

    always_comb begin
      if ((&rnd[ACC_W-1:OUT_W-1]) || ~(|rnd[ACC_W-1:OUT_W-1]))
        yo = rnd[OUT_W-1:0];
      else if (rnd[ACC_W-1])
        yo = {1'b1, {(OUT_W-1){1'b0}}};
      else
        yo = {1'b0, {(OUT_W-1){1'b1}}};
    end

    if (r == 0) begin : g_i
      assign y_i = yo;
    end else begin : g_q
      assign y_q = yo;
    end

    logic [HEAD_W-1:0] unused_head;
    assign unused_head = rnd[ACC_W-1:OUT_W-1];
  end

endmodule

// File: rtl/piq_sequencer.sv
module piq_sequencer
  import piq_pkg::*;
#(
  parameter int L_W    = 9,
  parameter int N_W    = 9,
  parameter int CA_W   = 8,
  parameter int DA_W   = 5,
  localparam int J_W   = ((N_W > L_W) ? N_W : L_W) + 1,
  localparam int K_MAX = (1 << DA_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  output logic            m_valid,
  input  logic            m_ready,
  input  logic [L_W-1:0]  cfg_l,
  input  logic [N_W-1:0]  cfg_taps,
  input  logic [CA_W-1:0] cfg_off,
  output logic            push,
  output logic            clr,
  output logic            en_i,
  output logic            en_q,
  output logic [CA_W-1:0] coef_addr,
  output logic [DA_W-1:0] age
);

  seq_state_t      st;
  logic [L_W-1:0]  l_q;
  logic [N_W-1:0]  n_q;
  logic [CA_W-1:0] off_q;
  logic [L_W-1:0]  ph;
  logic [DA_W-1:0] k;
  logic [J_W-1:0]  j;
  logic [J_W-1:0]  j_next;
  logic            no_taps;
  logic            branch_end;
  logic            last_phase;

  assign j_next     = j + J_W'(l_q);
  assign no_taps    = J_W'(ph) >= J_W'(n_q);
  assign branch_end = (j_next >= J_W'(n_q)) || (k == DA_W'(K_MAX));
  assign last_phase = (ph == (l_q - 1'b1));

  assign s_ready   = (st == SEQ_IDLE);
  assign m_valid   = (st == SEQ_OUT);
  assign push      = s_ready && s_valid;
  assign clr       = (st == SEQ_PHASE);
  assign en_i      = (st == SEQ_MAC_I);
  assign en_q      = (st == SEQ_MAC_Q);
  assign coef_addr = off_q + CA_W'(j);
  assign age       = k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      l_q   <= L_W'(1);
      n_q   <= N_W'(1);
      off_q <= '0;
      ph    <= '0;
      k     <= '0;
      j     <= '0;
    end else begin
      case (st)
        SEQ_IDLE: if (s_valid) begin
          l_q   <= cfg_l;
          n_q   <= cfg_taps;
          off_q <= cfg_off;
          ph    <= '0;
          st    <= SEQ_PHASE;
        end
        SEQ_PHASE: begin
          k  <= '0;
          j  <= J_W'(ph);
          st <= no_taps ? SEQ_OUT : SEQ_MAC_I;
        end
        SEQ_MAC_I: st <= SEQ_MAC_Q;
        SEQ_MAC_Q: begin
          if (branch_end) begin
            st <= SEQ_OUT;
          end else begin
            k  <= k + 1'b1;
            j  <= j_next;
            st <= SEQ_MAC_I;
          end
        end
        SEQ_OUT: if (m_ready) begin
          if (last_phase) begin
            st <= SEQ_IDLE;
          end else begin
            ph <= ph + 1'b1;
            st <= SEQ_PHASE;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/poly_iq_interp.sv
module poly_iq_interp #(
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 16,
  parameter int IN_FRAC    = 15,
  parameter int PROD_FRAC  = 18,
  parameter int ACC_W      = 22,
  parameter int OUT_W      = 18,
  parameter int CMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 32,
  parameter int MAX_L      = 256,
  parameter int MAX_TAPS   = 256,
  localparam int CA_W      = $clog2(CMEM_DEPTH),
  localparam int DA_W      = $clog2(DMEM_DEPTH),
  localparam int L_W       = $clog2(MAX_L) + 1,
  localparam int N_W       = $clog2(MAX_TAPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_i,
  input  logic [DATA_W-1:0] s_q,
  input  logic              cw_en,
  input  logic [CA_W-1:0]   cw_addr,
  input  logic [COEF_W-1:0] cw_data,
  input  logic [L_W-1:0]    cfg_l,
  input  logic [N_W-1:0]    cfg_taps,
  input  logic [CA_W-1:0]   cfg_off,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [OUT_W-1:0]  m_i,
  output logic [OUT_W-1:0]  m_q
);

  logic              push;
  logic              clr;
  logic              en_i;
  logic              en_q;
  logic [CA_W-1:0]   coef_addr;
  logic [DA_W-1:0]   age;
  logic [COEF_W-1:0] coef;
  logic [DATA_W-1:0] hist_i;
  logic [DATA_W-1:0] hist_q;

  piq_sequencer #(
    .L_W (L_W),
    .N_W (N_W),
    .CA_W(CA_W),
    .DA_W(DA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .cfg_l    (cfg_l),
    .cfg_taps (cfg_taps),
    .cfg_off  (cfg_off),
    .push     (push),
    .clr      (clr),
    .en_i     (en_i),
    .en_q     (en_q),
    .coef_addr(coef_addr),
    .age      (age)
  );

  piq_coef_store #(
    .COEF_W(COEF_W),
    .DEPTH (CMEM_DEPTH)
  ) u_coef (
    .clk    (clk),
    .wr_en  (cw_en),
    .wr_addr(cw_addr),
    .wr_data(cw_data),
    .rd_addr(coef_addr),
    .rd_data(coef)
  );

  piq_sample_ring #(
    .DATA_W(DATA_W),
    .DEPTH (DMEM_DEPTH)
  ) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .push_i(s_i),
    .push_q(s_q),
    .age   (age),
    .rd_i  (hist_i),
    .rd_q  (hist_q)
  );

  piq_mac #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .IN_FRAC  (IN_FRAC),
    .PROD_FRAC(PROD_FRAC),
    .ACC_W    (ACC_W),
    .OUT_W    (OUT_W)
  ) u_mac (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .en_i (en_i),
    .en_q (en_q),
    .d_i  (hist_i),
    .d_q  (hist_q),
    .coef (coef),
    .y_i  (m_i),
    .y_q  (m_q)
  );

endmodule

// File: rtl/piq_checker.sv
module piq_checker #(
  parameter int L_W   = 9,
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [OUT_W-1:0] m_i,
  input logic [OUT_W-1:0] m_q,
  input logic [L_W-1:0]   cfg_l
);

  logic [L_W:0]   out_cnt;
  logic [L_W-1:0] l_seen;
  logic           started;

  // counts handed-off outputs since the last accepted input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      l_seen  <= '0;
      started <= 1'b0;
    end else if (s_valid && s_ready) begin
      out_cnt <= '0;
      l_seen  <= cfg_l;
      started <= 1'b1;
    end else if (m_valid && m_ready) begin
      out_cnt <= out_cnt + 1'b1;
    end
  end

  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !m_valid);

  p_accept_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q)));

  p_phase_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && started) |-> (out_cnt == {1'b0, l_seen}));

endmodule

bind poly_iq_interp piq_checker #(
  .L_W  (L_W),
  .OUT_W(OUT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_i    (m_i),
  .m_q    (m_q),
  .cfg_l  (cfg_l)
);

// File: tb/poly_iq_interp_tb.sv
module poly_iq_interp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_i = '0;
  logic [15:0] s_q = '0;
  logic        cw_en = 1'b0;
  logic [7:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic [8:0]  cfg_l = 9'd1;
  logic [8:0]  cfg_taps = 9'd1;
  logic [7:0]  cfg_off = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [17:0] m_i;
  logic [17:0] m_q;

  int n_checks = 0;
  int n_fail = 0;
  int cmem [256];
  int h_i [32];
  int h_q [32];
  int exp_i [$];
  int exp_q [$];
  string exp_tag [$];
  int ready_pct = 100;
  bit hold_pend = 1'b0;
  logic [17:0] hold_i, hold_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  poly_iq_interp u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .cfg_l(cfg_l), .cfg_taps(cfg_taps), .cfg_off(cfg_off),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q)
  );

  task automatic check(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int sx16(int v);
    return (v << 16) >>> 16;
  endfunction

  // reference model of R4..R7, R11
  function automatic int model(bit rail_q, int p, int l, int n, int off);
    int acc;
    int j;
    int pr;
    int r;
    acc = 0;
    for (int k = 0; k < 32; k++) begin
      j = p + k * l;
      if (j >= n) break;
      pr = ((rail_q ? h_q[k] : h_i[k]) * cmem[(off + j) % 256]) >>> 12;
      acc = ((acc + pr) << 10) >>> 10;
    end
    r = (acc + 1) >>> 1;
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    return r;
  endfunction

  task automatic wr_coef(int addr, int val);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = 8'(addr); cw_data = 16'(val);
    cmem[addr % 256] = sx16(val);
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic push(int vi, int vq, int l, int n, int off, string tag);
    @(negedge clk);
    cfg_l = 9'(l); cfg_taps = 9'(n); cfg_off = 8'(off);
    s_i = 16'(vi); s_q = 16'(vq); s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    for (int k = 31; k > 0; k--) begin
      h_i[k] = h_i[k-1];
      h_q[k] = h_q[k-1];
    end
    h_i[0] = sx16(vi);
    h_q[0] = sx16(vq);
    for (int p = 0; p < l; p++) begin
      exp_i.push_back(model(1'b0, p, l, n, off));
      exp_q.push_back(model(1'b1, p, l, n, off));
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    s_valid = 1'b0;
    // R9: scramble configuration while this sample's outputs are pending
    cfg_l = 9'd7; cfg_taps = 9'd200; cfg_off = 8'd123;
    check("R2 ready low after accept", int'(s_ready), 0);
  endtask

  task automatic drain();
    while (exp_i.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard pop on each output transfer
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check("R10 valid held", int'(m_valid), 1);
        check("R10 data held", int'(m_i == hold_i && m_q == hold_q), 1);
      end
      m_ready = ($urandom_range(99) < ready_pct);
      hold_pend = m_valid && !m_ready;
      hold_i = m_i;
      hold_q = m_q;
      if (m_valid && m_ready) begin
        if (exp_i.size() == 0) begin
          check("R3 unexpected output", 1, 0);
        end else begin
          string t;
          int ei, eq, ai, aq;
          t = exp_tag.pop_front();
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          ai = $signed(m_i);
          aq = $signed(m_q);
          check({t, " I"}, ai, ei);
          check({t, " Q"}, aq, eq);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) begin h_i[k] = 0; h_q[k] = 0; end
    for (int a = 0; a < 256; a++) cmem[a] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(s_ready), 1);
    check("R1 no output after reset", int'(m_valid), 0);

    // base pattern everywhere, filter A at 10..41, filter B at 250..3 (wraps, R8)
    for (int a = 0; a < 256; a++) wr_coef(a, ((a * 131) % 2048) - 1024);
    for (int k = 0; k < 32; k++) wr_coef(10 + k, ((k * 977) % 8192) - 4096);
    for (int k = 0; k < 10; k++) wr_coef((250 + k) % 256, -3000 + k * 611);

    // R1/R4/R12: impulse on silent history, I and Q differ
    push(16'h4000, 16'hE000, 1, 8, 10, "R4 R12 impulse");
    for (int s = 0; s < 8; s++)
      push($urandom_range(65535), $urandom_range(65535), 1, 8, 10, "R4 L1");
    drain();

    ready_pct = 50;
    for (int s = 0; s < 6; s++)
      push($urandom_range(65535), $urandom_range(65535), 4, 16, 10, "R3 R4 R9 L4");
    for (int s = 0; s < 6; s++)
      push($urandom_range(65535), $urandom_range(65535), 3, 10, 10, "R4 L3");
    for (int s = 0; s < 4; s++)
      push($urandom_range(65535), $urandom_range(65535), 5, 3, 10, "R11 empty phases");
    for (int s = 0; s < 5; s++)
      push($urandom_range(65535), $urandom_range(65535), 2, 10, 250, "R8 wrap");
    ready_pct = 80;
    for (int s = 0; s < 2; s++)
      push($urandom_range(65535), $urandom_range(65535), 256, 256, 0, "R3 L max");
    for (int s = 0; s < 36; s++)
      push($urandom_range(65535), $urandom_range(65535), 1, 32, 10, "R4 depth32");
    drain();

    // R6 saturation both ways
    for (int k = 0; k < 6; k++) wr_coef(100 + k, 16'h7FFF);
    for (int s = 0; s < 6; s++) push(16'h7FFF, 16'h8000, 1, 6, 100, "R6 saturate");
    drain();

    // R7 and R5
    wr_coef(200, 16'h8000);
    wr_coef(201, 1);
    push(16'h8000, 16'h4000, 1, 1, 200, "R7 minus one squared");
    push(16'h1000, 16'hF000, 1, 1, 201, "R5 R6 round +-1");
    push(16'h3000, 16'hD000, 1, 1, 201, "R5 R6 round +-3");
    push(16'h0FFF, 16'hF001, 1, 1, 201, "R5 floor truncation");
    drain();

    check("R3 all outputs delivered", exp_i.size(), 0);
    check("R3 no extra output", int'(m_valid), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule